// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Matcher

This block picks, once per cell slot, which inputs of an N-by-N input-queued crossbar talk to which outputs. Every input holds a separate queue per output. The matcher sees only one occupancy bit per queue, and any non-empty queue counts as a request. A cell stuck waiting for a busy output therefore never hides cells bound for other outputs. The result is a grant matrix with at most one bit per row and per column, which drives the crosspoint enables directly.

Each matching round has three steps. Unmatched inputs request the free outputs they hold cells for. Each free output grants one requester, chosen round-robin from its own grant pointer. Each input accepts one of the grants it received, chosen round-robin from its own accept pointer. Rounds run one per clock. Later rounds re-offer only the ports still unmatched, so the matching grows toward maximal. The pointers move only on matches accepted in the first round, which keeps every queue from starving under sustained load.

A slot strobe captures the occupancy vector and the round limit. A one-cycle done pulse marks the point where the new grant matrix appears. The matrix then stays unchanged until the next done pulse.

Top module: `xbar_rr_matcher`

## Requirements
- R1: After reset the grant matrix is all zero, done and busy are low, and every grant and accept pointer is 0. The first all-ones slot after reset therefore pairs input 0 with output 0 in its first round.
- R2: Bit i*N+o of the grant matrix means input i drives output o. At most one bit is set per row and per column, and a bit is set only where the captured occupancy bit i*N+o (input i holds cells for output o) was 1.
- R3: The occupancy vector and the round limit are captured on a slot strobe seen while idle. A strobe seen while busy is ignored, and so are occupancy changes made while busy.
- R4: In each round, every free output grants the first requesting free input found by scanning upward, with wrap-around, from its grant pointer. Every input that received grants accepts the first one found by scanning upward, with wrap-around, from its accept pointer.
- R5: When a first-round grant from output o to input i is accepted, the grant pointer of o becomes i+1 mod N and the accept pointer of i becomes o+1 mod N. Grants that are not accepted, and matches made in later rounds, leave all pointers unchanged.
- R6: Pairs matched in a round are kept for the rest of the slot. Their input and output take no part in later rounds.
- R7: One round completes per clock. The slot ends after the round that reaches the limit, or after the first round that adds no new pair. A limit of 0, or a limit above MAX_ITER, is treated as MAX_ITER.
- R8: The done pulse lasts one cycle and appears with the new grant matrix. The matrix changes at no other time.
- R9: Under full load (all occupancy bits set) with the default limit, pointers desynchronise, and after 2N warm-up slots every input-output pair is granted at least once in any N consecutive slots.
- R10: Busy rises on the clock edge that captures a strobe. It stays high until the edge that raises done, and falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Slot strobe; starts a matching when idle |
| iter_limit | input | $clog2(MAX_ITER+1) | Round limit for the slot; 0 or above MAX_ITER means MAX_ITER |
| voq_occ | input | N*N | Occupancy bit per queue; bit i*N+o is input i toward output o |
| grant_mtx | output | N*N | Published matching; bit i*N+o enables crosspoint (i,o) |
| match_done | output | 1 | One-cycle pulse when a new matching is published |
| busy | output | 1 | High while rounds are running |

## Verification
A wrong pointer does not show up at once. The slot where it goes wrong can still publish a legal, conflict-free matrix, and the error appears one or more slots later as a different choice of pairs. For that reason the bench runs a pointer model across back-to-back slots and compares every published matrix with it, instead of checking legality alone. A wrong early-stop or round-count decision shows up in the same slot, as a done pulse in the wrong cycle. A pointer that moved on a later round or on an unaccepted grant shows up as a divergence within the next slot or two. A stuck pointer under full load shows up as a pair that is never served inside the N-slot window.

// File: rtl/xbar_match_pkg.sv
package xbar_match_pkg;

    // successor of a port index, wrapping at n
    function automatic int wrap_next(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/xbm_rr_pick.sv
// Round-robin picker: first set request at or after ptr, with wrap-around.
module xbm_rr_pick #(
    parameter int N  = 4,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt
);
    always_comb begin
        logic found;
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbm_iter.sv
// One request-grant-accept round over the still-unmatched ports.
module xbm_iter #(
    parameter int N  = 4,
    parameter int PW = $clog2(N)
) (
    input  logic [N*N-1:0]  req,
    input  logic [N*N-1:0]  match,
    input  logic [N*PW-1:0] gptr,
    input  logic [N*PW-1:0] aptr,
    output logic [N*N-1:0]  accept
);
    logic [N-1:0] in_busy;
    logic [N-1:0] out_busy;
    logic [N-1:0] col_req [N];
    logic [N-1:0] col_gnt [N];
    logic [N-1:0] row_gnt [N];
    logic [N-1:0] row_acc [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_busy[i] = |match[i*N +: N];
        end
        for (int o = 0; o < N; o++) begin
            out_busy[o] = 1'b0;
            for (int i = 0; i < N; i++) begin
                out_busy[o] = out_busy[o] | match[i*N + o];
            end
        end
    end

    // grant step: one picker per output, scanning inputs
    for (genvar o = 0; o < N; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < N; i++) begin
                col_req[o][i] = req[i*N + o] & ~in_busy[i] & ~out_busy[o];
            end
        end
        xbm_rr_pick #(.N(N), .PW(PW)) u_grant (
            .req (col_req[o]),
            .ptr (gptr[o*PW +: PW]),
            .gnt (col_gnt[o])
        );
    end

    // accept step: one picker per input, scanning outputs
    for (genvar i = 0; i < N; i++) begin : g_in
        always_comb begin
            for (int o = 0; o < N; o++) begin
                row_gnt[i][o] = col_gnt[o][i];
            end
        end
        xbm_rr_pick #(.N(N), .PW(PW)) u_accept (
            .req (row_gnt[i]),
            .ptr (aptr[i*PW +: PW]),
            .gnt (row_acc[i])
        );
        assign accept[i*N +: N] = row_acc[i];
    end
endmodule

// File: rtl/xbar_rr_matcher.sv
module xbar_rr_matcher
    import xbar_match_pkg::*;
#(
    parameter int N        = 4,
    parameter int MAX_ITER = 4,
    localparam int PW      = $clog2(N),
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_start,
    input  logic [IW-1:0]  iter_limit,
    input  logic [N*N-1:0] voq_occ,
    output logic [N*N-1:0] grant_mtx,
    output logic           match_done,
    output logic           busy
);
    typedef struct packed {
        logic            busy;
        logic            done;
        logic [IW-1:0]   iter;
        logic [IW-1:0]   lim;
        logic [N*N-1:0]  req;
        logic [N*N-1:0]  match;
        logic [N*N-1:0]  grant;
        logic [N*PW-1:0] gptr;
        logic [N*PW-1:0] aptr;
    } st_t;

    st_t st_d, st_q;
    logic [N*N-1:0] acc;
    logic [IW-1:0]  eff_lim;
    logic [IW-1:0]  iter_nxt;

    xbm_iter #(.N(N), .PW(PW)) u_iter (
        .req    (st_q.req),
        .match  (st_q.match),
        .gptr   (st_q.gptr),
        .aptr   (st_q.aptr),
        .accept (acc)
    );

    always_comb begin
        eff_lim  = (iter_limit == '0 || iter_limit > IW'(MAX_ITER)) ? IW'(MAX_ITER) : iter_limit;
        iter_nxt = st_q.iter + IW'(1);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (slot_start) begin
                st_d.busy  = 1'b1;
                st_d.iter  = '0;
                st_d.lim   = eff_lim;
                st_d.req   = voq_occ;
                st_d.match = '0;
            end
        end else begin
            st_d.match = st_q.match | acc;
            st_d.iter  = iter_nxt;
            if (st_q.iter == '0) begin
                for (int i = 0; i < N; i++) begin
                    for (int o = 0; o < N; o++) begin
                        if (acc[i*N + o]) begin
                            st_d.gptr[o*PW +: PW] = PW'(wrap_next(i, N));
                            st_d.aptr[i*PW +: PW] = PW'(wrap_next(o, N));
                        end
                    end
                end
            end
            if (acc == '0 || iter_nxt == st_q.lim) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.grant = st_q.match | acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_mtx  = st_q.grant;
    assign match_done = st_q.done;
    assign busy       = st_q.busy;

    // ---------------- assertions ----------------
    logic [N-1:0] chk_col [N];
    always_comb begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                chk_col[o][i] = st_q.grant[i*N + o];
            end
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_chk
        p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_mtx[k*N +: N]));
        p_col_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(chk_col[k]));
    end

    p_grant_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |-> ((grant_mtx & ~st_q.req) == '0));
    p_strobe_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && slot_start) |=> (busy && st_q.req == $past(voq_occ)));
    p_strobe_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(st_q.req));
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || st_q.iter != '0) |=> ($stable(st_q.gptr) && $stable(st_q.aptr)));
    p_match_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.iter != '0) |-> ((st_q.match & $past(st_q.match)) == $past(st_q.match)));
    p_iter_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.iter < st_q.lim));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |=> !match_done);
    p_grant_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !match_done |-> $stable(grant_mtx));
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_done |-> !busy);
    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> match_done);
endmodule

// File: tb/tb_xbar_rr_matcher.sv
module tb_xbar_rr_matcher;
    localparam int NP  = 4;
    localparam int MI  = 4;
    localparam int NV  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_start = 1'b0;
    logic [2:0]  iter_limit = 3'd4;
    logic [15:0] voq_occ = '0;
    logic [15:0] grant_mtx;
    logic        match_done;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int mgp [NP];
    int map [NP];

    localparam logic [15:0] OCC_TAB [NV] = '{16'hFFFF, 16'h0000, 16'h1111, 16'h8421,
                                             16'h00F1, 16'h3C5A, 16'hFFFF, 16'hA5A5};
    localparam int LIM_TAB [NV] = '{4, 4, 4, 1, 1, 2, 0, 7};

    always #5 clk = ~clk;

    xbar_rr_matcher #(.N(NP), .MAX_ITER(MI)) dut (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .iter_limit(iter_limit),
        .voq_occ(voq_occ), .grant_mtx(grant_mtx), .match_done(match_done), .busy(busy)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // independent pointer model of the matching rules
    task automatic model_slot(input logic [15:0] occ, input int lim,
                              output logic [15:0] m, output int iters);
        int eff;
        eff = (lim == 0 || lim > MI) ? MI : lim;
        m = '0;
        iters = 0;
        for (int it = 0; it < eff; it++) begin
            logic [NP-1:0] gcol [NP];
            logic [NP-1:0] in_m, out_m;
            int added;
            added = 0;
            for (int p = 0; p < NP; p++) begin
                in_m[p] = |m[p*NP +: NP];
                out_m[p] = m[p] | m[NP+p] | m[2*NP+p] | m[3*NP+p];
            end
            for (int o = 0; o < NP; o++) begin
                gcol[o] = '0;
                if (!out_m[o]) begin
                    for (int k = 0; k < NP; k++) begin
                        int i;
                        i = (mgp[o] + k) % NP;
                        if (!in_m[i] && occ[i*NP + o]) begin
                            gcol[o][i] = 1'b1;
                            break;
                        end
                    end
                end
            end
            for (int i = 0; i < NP; i++) begin
                if (!in_m[i]) begin
                    for (int k = 0; k < NP; k++) begin
                        int o;
                        o = (map[i] + k) % NP;
                        if (gcol[o][i]) begin
                            m[i*NP + o] = 1'b1;
                            added++;
                            if (it == 0) begin
                                mgp[o] = (i + 1) % NP;
                                map[i] = (o + 1) % NP;
                            end
                            break;
                        end
                    end
                end
            end
            iters++;
            if (added == 0) break;
        end
    endtask

    // issue one slot; returns published matrix and rounds counted until done
    task automatic run_slot(input logic [15:0] occ, input int lim, input logic extra_strobe,
                            output logic [15:0] g, output int cyc);
        logic [15:0] prev;
        prev = grant_mtx;
        @(negedge clk);
        voq_occ = occ;
        iter_limit = 3'(lim);
        slot_start = 1'b1;
        @(posedge clk);
        #1 slot_start = 1'b0;
        cyc = 0;
        while (cyc < 20) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (match_done) break;
            check(busy === 1'b1, "R10", "busy during rounds", 32'(busy), 32'd1);
            check(grant_mtx === prev, "R8", "grant held while busy", 32'(grant_mtx), 32'(prev));
            if (extra_strobe && cyc == 1) begin
                voq_occ = ~occ;
                iter_limit = 3'd1;
                slot_start = 1'b1;
                @(posedge clk);
                #1 slot_start = 1'b0;
                voq_occ = 16'h0;
                cyc++;
                @(negedge clk);
                if (match_done) break;
            end
        end
        g = grant_mtx;
        check(busy === 1'b0, "R10", "busy low at done", 32'(busy), 32'd0);
    endtask

    task automatic legal(input logic [15:0] g, input logic [15:0] occ);
        logic ok;
        ok = ((g & ~occ) == 16'h0);
        for (int p = 0; p < NP; p++) begin
            if ($countones(g[p*NP +: NP]) > 1) ok = 1'b0;
            if ($countones({g[p], g[NP+p], g[2*NP+p], g[3*NP+p]}) > 1) ok = 1'b0;
        end
        check(ok, "R2", "conflict-free within occupancy", 32'(g), 32'(occ));
    endtask

    initial begin : watchdog
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] g, exp;
        int cyc, iters;
        logic [15:0] seen;
        for (int p = 0; p < NP; p++) begin
            mgp[p] = 0;
            map[p] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(grant_mtx === 16'h0, "R1", "grant after reset", 32'(grant_mtx), 32'd0);
        check(match_done === 1'b0, "R1", "done after reset", 32'(match_done), 32'd0);
        check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);

        // table walk: R4 R5 R6 R7 against the model
        for (int v = 0; v < NV; v++) begin
            model_slot(OCC_TAB[v], LIM_TAB[v], exp, iters);
            run_slot(OCC_TAB[v], LIM_TAB[v], 1'b0, g, cyc);
            if (v == 0)
                check(g[0] === 1'b1, "R1", "pointers zero: pair 0-0 first", 32'(g), 32'(exp));
            check(g === exp, "R4 R5 R6", "matching vs model", 32'(g), 32'(exp));
            check(cyc == iters, "R7", "rounds until done", 32'(cyc), 32'(iters));
            legal(g, OCC_TAB[v]);
        end

        // R3: strobe and occupancy change while busy are ignored
        model_slot(16'h6F39, 4, exp, iters);
        run_slot(16'h6F39, 4, 1'b1, g, cyc);
        check(g === exp, "R3", "busy strobe ignored", 32'(g), 32'(exp));
        check(cyc == iters, "R3", "rounds unaffected", 32'(cyc), 32'(iters));
        @(negedge clk);
        check(busy === 1'b0 && match_done === 1'b0, "R3", "no second run started",
              32'({busy, match_done}), 32'd0);
        check(grant_mtx === exp, "R8", "grant held after done", 32'(grant_mtx), 32'(exp));

        // R7: limit 1 with output conflict leaves ports unmatched
        model_slot(16'h3333, 1, exp, iters);
        run_slot(16'h3333, 1, 1'b0, g, cyc);
        check(g === exp && cyc == 1, "R7", "single round limit", 32'(g), 32'(exp));

        // R9: full load fairness
        seen = '0;
        for (int s = 0; s < 3 * NP; s++) begin
            model_slot(16'hFFFF, 4, exp, iters);
            run_slot(16'hFFFF, 4, 1'b0, g, cyc);
            check(g === exp, "R9", "full-load slot vs model", 32'(g), 32'(exp));
            if (s >= 2 * NP) seen = seen | g;
        end
        check(seen === 16'hFFFF, "R9", "every pair served in N slots", 32'(seen), 32'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule